// File: doc/BRIEF.md
# Variable-Rate Sinc3 Decimator

This block turns one-bit delta-sigma modulator streams into signed 24-bit samples through a third-order sinc decimation filter, H(z) = ((1 − z^−N)/(1 − z^−1))^3. It generates the modulator sample tick itself by dividing the master clock: by 4 in high-resolution mode and by 8 in low-power mode. A 3-bit rate code selects the decimation ratio N at run time. The ratio is global, so every channel instance shares one timing engine and produces its word in the same cycle.

Each channel is built from three integrators that advance on the modulator tick and three differentiators that advance once per N ticks. The result is scaled so that a full-scale input lands on the 24-bit limit, and it is saturated there. The valid strobe stays low until the filter has settled, which takes four output periods after an enable or a rate change. A new rate code is taken up only at an output boundary, so a frame is never cut short.

Top module: `sinc3_decim`

## Requirements
- R1: While en_i is high, mod_tick_o pulses for one cycle every 4 clocks when mode_i=0 (high resolution) and every 8 clocks when mode_i=1 (low power). While en_i is low it never pulses. The mod_bit_i bits are sampled in each tick cycle.
- R2: Rate codes 0..6 select N = 16, 32, 64, 128, 256, 512, 1024, and code 7 selects N = 1024. Once settled, valid_o pulses for one cycle every N ticks (N×4 or N×8 clocks).
- R3: After en_i rises, the first valid_o comes at the fourth output boundary, which is exactly 4×N×D clocks after the first clock edge that sees en_i high (D = 4 or 8).
- R4: Input bit 1 counts as +1 and bit 0 as −1. A settled word equals the mean input times 2^23: a repeating 1,1,1,0 pattern gives 0x400000, a repeating 1,0,0,0 pattern gives 0xC00000, and an alternating pattern gives 0x000000.
- R5: Results are saturated to 24-bit two's complement. Constant ones give 0x7FFFFF and constant zeros give 0x800000.
- R6: A change of rate_i while running is applied at the next output boundary under the old N. That boundary emits no word and clears the integrators, and the next valid_o comes four boundaries later under the new N.
- R7: All channels use the same rate and strobe, and each channel's word depends only on its own mod_bit_i bit. Channel c sits at sample_o[24c+23:24c].
- R8: Dropping en_i clears the filter state and stops valid_o and mod_tick_o from the next clock edge on.
- R9: After reset, valid_o and mod_tick_o are low and sample_o is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Master clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Run enable; low clears and idles the filter |
| mode_i | input | 1 | 0 = high resolution (clock/4), 1 = low power (clock/8) |
| rate_i | input | 3 | Decimation rate code |
| mod_bit_i | input | NUM_CH | Modulator bit per channel |
| mod_tick_o | output | 1 | Modulator sample strobe |
| valid_o | output | 1 | Output word strobe, common to all channels |
| sample_o | output | NUM_CH*24 | Packed signed output words |

## Verification
The bench uses two channels with the default widths: a 24-bit output, ratios from 16 to 1024, and dividers of 4 and 8. With two channels it can drive opposite patterns on the same strobe, which exercises the per-channel data paths against the shared timing. Keeping the full ratio range in the build means codes 6 and 7 run at N = 1024. There the 32-bit integrators wrap many times per frame and the right-shift scaling path is used, while N = 16 uses the left-shift path. Both positive and negative saturation limits, together with exact mid-scale values, are within reach of periodic input patterns.

// File: rtl/sinc3_pkg.sv
package sinc3_pkg;
  typedef enum logic {
    PWR_HIRES  = 1'b0,
    PWR_LOWPWR = 1'b1
  } pwr_mode_e;
endpackage

// File: rtl/sinc3_timing.sv
module sinc3_timing #(
  parameter int unsigned RATE_W     = 3,
  parameter int unsigned MIN_LOG2   = 4,
  parameter int unsigned MAX_LOG2   = 10,
  parameter int unsigned HR_DIV     = 4,
  parameter int unsigned LP_DIV     = 8,
  parameter int unsigned SETTLE_CNT = 4,
  localparam int unsigned LOG_W     = $clog2(MAX_LOG2 + 1),
  localparam int unsigned DIV_W     = $clog2(LP_DIV),
  localparam int unsigned SET_W     = $clog2(SETTLE_CNT)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  sinc3_pkg::pwr_mode_e mode_i,
  input  logic [RATE_W-1:0] rate_i,
  output logic             tick_o,
  output logic             bnd_o,
  output logic             clear_o,
  output logic             emit_o,
  output logic             valid_o,
  output logic [LOG_W-1:0] log2n_o
);
  import sinc3_pkg::*;

  logic [DIV_W-1:0]    div_q, div_max;
  logic [MAX_LOG2-1:0] samp_q, n_last;
  logic [MAX_LOG2:0]   n_full;
  logic [RATE_W-1:0]   rate_q;
  logic [SET_W-1:0]    settle_q;
  logic                change;

  assign div_max = (mode_i == PWR_LOWPWR) ? DIV_W'(LP_DIV - 1) : DIV_W'(HR_DIV - 1);
  assign tick_o  = en_i && (div_q >= div_max);

  always_comb begin
    if (int'(rate_q) > int'(MAX_LOG2 - MIN_LOG2)) log2n_o = LOG_W'(MAX_LOG2);
    else                                          log2n_o = LOG_W'(MIN_LOG2 + int'(rate_q));
  end

  assign n_full  = {{MAX_LOG2{1'b0}}, 1'b1} << log2n_o;
  assign n_last  = MAX_LOG2'(n_full - 1'b1);
  assign bnd_o   = tick_o && (samp_q == n_last);
  assign change  = bnd_o && (rate_i != rate_q);
  assign clear_o = !en_i || change;
  assign emit_o  = bnd_o && !change && (settle_q == SET_W'(SETTLE_CNT - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      div_q    <= '0;
      samp_q   <= '0;
      rate_q   <= '0;
      settle_q <= '0;
      valid_o  <= 1'b0;
    end else begin
      valid_o <= emit_o;
      if (!en_i) begin
        div_q    <= '0;
        samp_q   <= '0;
        rate_q   <= rate_i;
        settle_q <= '0;
      end else begin
        div_q <= tick_o ? '0 : div_q + 1'b1;
        if (bnd_o)       samp_q <= '0;
        else if (tick_o) samp_q <= samp_q + 1'b1;
        if (change) begin
          rate_q   <= rate_i;
          settle_q <= '0;
        end else if (bnd_o && settle_q != SET_W'(SETTLE_CNT - 1)) begin
          settle_q <= settle_q + 1'b1;
        end
      end
    end
  end

  AST_TICK_SPACING: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |=> !tick_o); // R1
  AST_VALID_SPACING: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> !valid_o); // R2
  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (!valid_o && !tick_o)); // R8
  AST_RATE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !bnd_o) |=> $stable(rate_q)); // R6
endmodule

// File: rtl/sinc3_integ.sv
module sinc3_integ #(
  parameter int unsigned ACC_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clear_i,
  input  logic             tick_i,
  input  logic             bit_i,
  output logic [ACC_W-1:0] acc_o
);
  logic [ACC_W-1:0] i1_q, i2_q, i3_q, x;

  assign x     = bit_i ? ACC_W'(1) : '1;
  assign acc_o = i3_q;

  // modular accumulators; wraparound cancels in the differentiators
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      i1_q <= '0;
      i2_q <= '0;
      i3_q <= '0;
    end else if (clear_i) begin
      i1_q <= '0;
      i2_q <= '0;
      i3_q <= '0;
    end else if (tick_i) begin
      i1_q <= i1_q + x;
      i2_q <= i2_q + i1_q;
      i3_q <= i3_q + i2_q;
    end
  end

  AST_INTEG_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> (i1_q == '0 && i2_q == '0 && i3_q == '0)); // R6
endmodule

// File: rtl/sinc3_comb.sv
module sinc3_comb #(
  parameter int unsigned ACC_W = 32,
  parameter int unsigned OUT_W = 24,
  parameter int unsigned LOG_W = 4,
  localparam int unsigned EXT_W = ACC_W + OUT_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clear_i,
  input  logic             bnd_i,
  input  logic             emit_i,
  input  logic [LOG_W-1:0] log2n_i,
  input  logic [ACC_W-1:0] acc_i,
  output logic [OUT_W-1:0] sample_o
);
  localparam logic signed [EXT_W-1:0] SAT_HI = {{(EXT_W-OUT_W+1){1'b0}}, {(OUT_W-1){1'b1}}};
  localparam logic signed [EXT_W-1:0] SAT_LO = {{(EXT_W-OUT_W+1){1'b1}}, {(OUT_W-1){1'b0}}};

  logic [ACC_W-1:0] c0_z, d1_z, d2_z, d1, d2, d3;
  logic signed [EXT_W-1:0] ext, scaled;
  logic [OUT_W-1:0] sat;
  int shift_s;

  assign d1 = acc_i - c0_z;
  assign d2 = d1 - d1_z;
  assign d3 = d2 - d2_z;

  // full scale N^3 = 2^(3*log2n) maps onto 2^(OUT_W-1)
  always_comb begin
    shift_s = 3 * int'(log2n_i) - int'(OUT_W - 1);
    ext     = {{OUT_W{d3[ACC_W-1]}}, d3};
    if (shift_s >= 0) scaled = ext >>> shift_s;
    else              scaled = ext <<< (-shift_s);
    if (scaled > SAT_HI)      sat = SAT_HI[OUT_W-1:0];
    else if (scaled < SAT_LO) sat = SAT_LO[OUT_W-1:0];
    else                      sat = scaled[OUT_W-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      c0_z     <= '0;
      d1_z     <= '0;
      d2_z     <= '0;
      sample_o <= '0;
    end else if (clear_i) begin
      c0_z <= '0;
      d1_z <= '0;
      d2_z <= '0;
    end else if (bnd_i) begin
      c0_z <= acc_i;
      d1_z <= d1;
      d2_z <= d2;
      if (emit_i) sample_o <= sat;
    end
  end

  AST_COMB_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> (c0_z == '0 && d1_z == '0 && d2_z == '0)); // R6
  AST_SAMPLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !emit_i |=> $stable(sample_o)); // R2
endmodule

// File: rtl/sinc3_decim.sv
module sinc3_decim #(
  parameter int unsigned NUM_CH   = 2,
  parameter int unsigned OUT_W    = 24,
  parameter int unsigned RATE_W   = 3,
  parameter int unsigned MIN_LOG2 = 4,
  parameter int unsigned MAX_LOG2 = 10,
  parameter int unsigned HR_DIV   = 4,
  parameter int unsigned LP_DIV   = 8,
  parameter int unsigned SETTLE_CNT = 4,
  localparam int unsigned ACC_W   = 3 * MAX_LOG2 + 2,
  localparam int unsigned LOG_W   = $clog2(MAX_LOG2 + 1)
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    en_i,
  input  logic                    mode_i,
  input  logic [RATE_W-1:0]       rate_i,
  input  logic [NUM_CH-1:0]       mod_bit_i,
  output logic                    mod_tick_o,
  output logic                    valid_o,
  output logic [NUM_CH*OUT_W-1:0] sample_o
);
  import sinc3_pkg::*;

  logic             bnd, clear, emit;
  logic [LOG_W-1:0] log2n;
  pwr_mode_e        mode;

  assign mode = pwr_mode_e'(mode_i);

  sinc3_timing #(
    .RATE_W(RATE_W), .MIN_LOG2(MIN_LOG2), .MAX_LOG2(MAX_LOG2),
    .HR_DIV(HR_DIV), .LP_DIV(LP_DIV), .SETTLE_CNT(SETTLE_CNT)
  ) i_timing (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(en_i), .mode_i(mode), .rate_i(rate_i),
    .tick_o(mod_tick_o), .bnd_o(bnd), .clear_o(clear), .emit_o(emit),
    .valid_o(valid_o), .log2n_o(log2n)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic [ACC_W-1:0] acc;

    sinc3_integ #(.ACC_W(ACC_W)) i_integ (
      .clk_i(clk_i), .rst_ni(rst_ni), .clear_i(clear), .tick_i(mod_tick_o),
      .bit_i(mod_bit_i[c]), .acc_o(acc)
    );

    sinc3_comb #(.ACC_W(ACC_W), .OUT_W(OUT_W), .LOG_W(LOG_W)) i_comb (
      .clk_i(clk_i), .rst_ni(rst_ni), .clear_i(clear), .bnd_i(bnd), .emit_i(emit),
      .log2n_i(log2n), .acc_i(acc), .sample_o(sample_o[c*OUT_W +: OUT_W])
    );
  end

  AST_RESET_VALUE: assert property (@(posedge clk_i)
    !rst_ni |=> (!valid_o && sample_o == '0)); // R9
endmodule

// File: tb/test_sinc3_decim.sv
module test_sinc3_decim;
  localparam int NUM_CH = 2;
  localparam int OUT_W  = 24;

  localparam int P_ZERO = 0, P_ONE = 1, P_ALT = 2, P_HI3 = 3, P_LO1 = 4;

  logic clk_i = 1'b0, rst_ni = 1'b0, en_i = 1'b0, mode_i = 1'b0;
  logic [2:0] rate_i = '0;
  logic [NUM_CH-1:0] mod_bit_i;
  logic mod_tick_o, valid_o;
  logic [NUM_CH*OUT_W-1:0] sample_o;

  int checks = 0, errors = 0;
  int pat0 = P_ZERO, pat1 = P_ZERO;
  int unsigned idx = 0;
  bit done = 1'b0;

  always #5 clk_i = ~clk_i;

  sinc3_decim #(.NUM_CH(NUM_CH)) i_sinc3_decim (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(en_i), .mode_i(mode_i), .rate_i(rate_i),
    .mod_bit_i(mod_bit_i), .mod_tick_o(mod_tick_o), .valid_o(valid_o), .sample_o(sample_o)
  );

  function automatic logic pat_bit(int p, int unsigned i);
    case (p)
      P_ONE:   return 1'b1;
      P_ALT:   return i[0];
      P_HI3:   return (i % 4) != 3;
      P_LO1:   return (i % 4) == 0;
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic [OUT_W-1:0] exp_word(int p);
    case (p)
      P_ONE:   return 24'h7FFFFF;
      P_ALT:   return 24'h000000;
      P_HI3:   return 24'h400000;
      P_LO1:   return 24'hC00000;
      default: return 24'h800000;
    endcase
  endfunction

  function automatic int ratio(int code);
    return (code >= 6) ? 1024 : (16 << code);
  endfunction

  // bench modulator model
  always @(posedge clk_i) begin
    if (!en_i) idx <= 0;
    else if (mod_tick_o) idx <= idx + 1;
  end
  assign mod_bit_i = {pat_bit(pat1, idx), pat_bit(pat0, idx)};

  task automatic check(bit ok, string req, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // count clocks until the next valid_o, sampled on falling edges
  task automatic wait_valid(int limit, output int n);
    n = 0;
    do begin
      @(negedge clk_i);
      n++;
    end while (!valid_o && n <= limit);
  endtask

  task automatic stop_run();
    @(negedge clk_i);
    en_i = 1'b0;
    repeat (3) @(negedge clk_i);
  endtask

  task automatic run_case(string req, bit lp, int code, int p0, int p1);
    int n, d, nr;
    d  = lp ? 8 : 4;
    nr = ratio(code);
    @(negedge clk_i);
    mode_i = lp; rate_i = 3'(code); pat0 = p0; pat1 = p1;
    @(negedge clk_i);
    en_i = 1'b1;
    wait_valid(4 * nr * d + 10, n);
    check(n == 4 * nr * d, "R3 first valid delay", n, 4 * nr * d);
    check(sample_o[OUT_W-1:0] == exp_word(p0), req, sample_o[OUT_W-1:0], exp_word(p0));
    check(sample_o[2*OUT_W-1:OUT_W] == exp_word(p1), "R7 channel 1", sample_o[2*OUT_W-1:OUT_W], exp_word(p1));
    wait_valid(nr * d + 10, n);
    check(n == nr * d, "R2 valid interval", n, nr * d);
    check(sample_o[OUT_W-1:0] == exp_word(p0), req, sample_o[OUT_W-1:0], exp_word(p0));
    stop_run();
  endtask

  task automatic test_reset();
    @(negedge clk_i);
    check(valid_o == 1'b0, "R9 valid", valid_o, 0);
    check(sample_o == '0, "R9 sample", sample_o[OUT_W-1:0], 0);
    check(mod_tick_o == 1'b0, "R9 tick", mod_tick_o, 0);
  endtask

  task automatic test_tick(bit lp);
    int gap, first, ticks;
    @(negedge clk_i);
    mode_i = lp; rate_i = 3'd3; pat0 = P_ALT; pat1 = P_ALT;
    @(negedge clk_i);
    en_i = 1'b1;
    first = -1; gap = 0; ticks = 0;
    for (int k = 1; k <= 64; k++) begin
      @(negedge clk_i);
      if (mod_tick_o) begin
        if (first >= 0 && gap == 0) gap = k - first;
        if (first < 0) first = k;
        ticks++;
      end
    end
    check(gap == (lp ? 8 : 4), "R1 tick period", gap, lp ? 8 : 4);
    check(ticks == (lp ? 8 : 16), "R1 tick count", ticks, lp ? 8 : 16);
    stop_run();
  endtask

  task automatic test_rate_change();
    int n;
    @(negedge clk_i);
    mode_i = 1'b0; rate_i = 3'd0; pat0 = P_HI3; pat1 = P_LO1;
    @(negedge clk_i);
    en_i = 1'b1;
    wait_valid(300, n);
    @(negedge clk_i);
    rate_i = 3'd1;
    wait_valid(700, n);
    // the old frame runs out (63 clocks left) then four new frames of 128
    check(n + 1 == 64 + 4 * 128, "R6 delay after rate change", n + 1, 64 + 4 * 128);
    check(sample_o[OUT_W-1:0] == 24'h400000, "R6 value after change", sample_o[OUT_W-1:0], 24'h400000);
    wait_valid(200, n);
    check(n == 128, "R6 new interval", n, 128);
    stop_run();
  endtask

  task automatic test_disable();
    int n, seen;
    @(negedge clk_i);
    mode_i = 1'b0; rate_i = 3'd0; pat0 = P_ONE; pat1 = P_ZERO;
    @(negedge clk_i);
    en_i = 1'b1;
    wait_valid(300, n);
    @(negedge clk_i);
    en_i = 1'b0;
    seen = 0;
    for (int k = 0; k < 600; k++) begin
      @(negedge clk_i);
      if (valid_o || mod_tick_o) seen++;
    end
    check(seen == 0, "R8 quiet while disabled", seen, 0);
    check(sample_o[OUT_W-1:0] == 24'h7FFFFF, "R8 last word held", sample_o[OUT_W-1:0], 24'h7FFFFF);
    // re-enable: full settle again
    en_i = 1'b1;
    wait_valid(300, n);
    check(n == 256, "R8 restart settles again", n, 256);
    stop_run();
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    test_reset();
    rst_ni = 1'b1;
    test_tick(1'b0);
    test_tick(1'b1);
    run_case("R5 positive saturation", 1'b0, 0, P_ONE, P_ZERO);
    run_case("R5 negative saturation", 1'b0, 1, P_ZERO, P_ONE);
    run_case("R4 three-quarter duty", 1'b0, 2, P_HI3, P_LO1);
    run_case("R4 alternating", 1'b0, 3, P_ALT, P_HI3);
    run_case("R1 low-power mode", 1'b1, 0, P_LO1, P_ALT);
    run_case("R2 code 7 as 1024", 1'b0, 7, P_HI3, P_ONE);
    run_case("R2 code 6 low power", 1'b1, 6, P_ALT, P_ZERO);
    test_rate_change();
    test_disable();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule